// File: doc/BRIEF.md
# I2C Register-File Slave for an LED Blinker

This block is the serial front end of a small LED blink controller. A bus master addresses it over a two-wire I2C bus and reaches a bank of six 8-bit locations. Slot 0 is read-only and returns the live pin levels. The other five slots hold the two blink prescalers, the two blink duty values and the LED source selector. A command byte sets a 3-bit pointer and an optional auto-increment flag, so the master can program the whole bank in one burst.

The block takes SCL and SDA already synchronised to the system clock. It filters short spikes off both lines and detects START, repeated START and STOP. It matches a fixed 7-bit address and acknowledges each byte it accepts. On a read it drives data out MSB first through an open-drain enable, and it releases the line when the master does not acknowledge. The register values go straight to the blink logic. Each accepted write also raises a one-cycle strobe for the register that was written.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal parameter `SLAVE_ADDR` (default 7'h62, so C4h writes and C5h reads), where bit 0 is 1 for read and 0 for write. It does not acknowledge any other address, and it ignores the rest of that transfer.
- R2: The first byte after an acknowledged write address is the command byte. Its bits 2:0 load the pointer and its bit 4 loads the auto-increment flag. Both are zero after reset.
- R3: Pointer codes map to locations as follows: 0 = pin levels, 1 = prescaler 0, 2 = duty 0, 3 = prescaler 1, 4 = duty 1, 5 = LED select. Each later write byte lands at the pointer, is acknowledged and appears on the matching output.
- R4: With auto-increment set, the pointer advances after every data byte read or written. It goes from 5 to 0. Codes 6 and 7 read as 00h, ignore writes and also step to 0.
- R5: With auto-increment clear, the pointer stays fixed, so repeated data bytes hit the same location.
- R6: A write aimed at location 0 is acknowledged but changes no register and raises no strobe.
- R7: Each accepted write to locations 1 to 5 pulses bit `n` of `wr_stb_o` (n = pointer) for one clock. At most one bit is high at a time, and bit 0 never is.
- R8: Read data leaves MSB first. The slave releases SDA after the eighth bit. A master ACK (SDA low) fetches the next byte, and a master NACK ends the read with the line left released.
- R9: A repeated START returns the slave to address matching and keeps the stored pointer.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` clocks has no effect on the bus state.
- R11: A read that has no command byte in front of it starts at the pointer left by the previous transfer.
- R12: After reset SDA is released, both prescalers are FFh, both duties are 80h and the LED selector is 55h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| pins_i | input | 8 | Live pin levels returned at location 0 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| presc0_o | output | 8 | Prescaler 0 value |
| duty0_o | output | 8 | Duty 0 value |
| presc1_o | output | 8 | Prescaler 1 value |
| duty1_o | output | 8 | Duty 1 value |
| ledsel_o | output | 8 | LED source selector value |
| wr_stb_o | output | 6 | One-cycle write strobe, one bit per location |

## Verification
On the same SCL falling edge the slave commits a write, advances the pointer and drives its acknowledge. A burst that starts at location 5 with auto-increment set makes the wrap to 0 fall in that same cycle, and so does the read burst that crosses from the selector to the pin register. The bench judges both cases with a behavioural model: it compares every register output on each clock outside the byte being clocked, and it checks the byte that follows the wrap. Filtered spikes are placed inside the high phase of data bits, where a missed spike would add a clock or fake a START or STOP. The bench then checks that the byte still lands intact.

// File: rtl/i2crf_pkg.sv
// Shared widths, register indices and bus-engine state type for the
// I2C register-file slave.
package i2crf_pkg;
    localparam int REG_W    = 8;
    localparam int PTR_W    = 3;
    localparam int NUM_REGS = 6;

    localparam int IDX_PINS  = 0;
    localparam int IDX_PSC0  = 1;
    localparam int IDX_DUTY0 = 2;
    localparam int IDX_PSC1  = 3;
    localparam int IDX_DUTY1 = 4;
    localparam int IDX_LSEL  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_MACK
    } bus_st_t;

    // Pointer step with wrap to zero past the last location.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (int'(p) >= NUM_REGS - 1) ? '0 : p + PTR_W'(1);
    endfunction
endpackage

// File: rtl/i2crf_glitch_filter.sv
// Spike filter for one bus line. The output takes a new level only after
// the input has held that level for FILT_LEN consecutive clocks.
// Assumes the input is already synchronised to clk. Idle level is high.
module i2crf_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [CW-1:0] run_cnt;

    // Count the run of differing samples and accept the level at FILT_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_o  <= 1'b1;
            run_cnt <= '0;
        end else if (raw_i == filt_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            filt_o  <= raw_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R10: the output only ever moves to a level the input already showed
    p_filter_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));
endmodule

// File: rtl/i2crf_regbank.sv
// Register bank: five writable locations with parameterised reset values,
// the read-only pin location, a read multiplexer and one-hot write strobes.
// Assumes at most one write request per clock from the bus engine.
module i2crf_regbank
    import i2crf_pkg::*;
#(
    parameter logic [REG_W-1:0] PSC_RST  = 8'hFF,
    parameter logic [REG_W-1:0] DUTY_RST = 8'h80,
    parameter logic [REG_W-1:0] LSEL_RST = 8'h55
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          wr_ptr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]          rd_ptr,
    input  logic [REG_W-1:0]          pins_i,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] reg_flat,
    output logic [NUM_REGS-1:0]       wr_stb
);
    function automatic logic [REG_W-1:0] rst_val(input int idx);
        if (idx == IDX_PSC0 || idx == IDX_PSC1)   return PSC_RST;
        if (idx == IDX_DUTY0 || idx == IDX_DUTY1) return DUTY_RST;
        return LSEL_RST;
    endfunction

    assign reg_flat[REG_W-1:0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        // Hold one writable location.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_flat[g*REG_W +: REG_W] <= rst_val(g);
            else if (wr_en && wr_ptr == PTR_W'(g))
                reg_flat[g*REG_W +: REG_W] <= wr_data;
        end
    end

    // Raise a one-clock strobe for the written location (never location 0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                wr_stb[i] <= wr_en && (i != IDX_PINS) && (wr_ptr == PTR_W'(i));
        end
    end

    // Select read data: pins at 0, stored values at 1..5, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_ptr == PTR_W'(IDX_PINS)) rd_data = pins_i;
        for (int i = 1; i < NUM_REGS; i++)
            if (rd_ptr == PTR_W'(i)) rd_data = reg_flat[i*REG_W +: REG_W];
    end

    // R7: strobes are one-hot or idle and location 0 never strobes
    p_stb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb) && !wr_stb[IDX_PINS]);
    // R6: a write aimed at the pin location leaves the bank untouched
    p_pins_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == PTR_W'(IDX_PINS)) |=> $stable(reg_flat));
endmodule

// File: rtl/i2crf_bus_engine.sv
// I2C slave protocol engine working on filtered SCL/SDA. It detects START
// and STOP, matches the address, stores the command byte, issues write
// requests and serialises read data with acknowledge handling.
// Assumes filtered lines and a master that keeps SDA stable while SCL is high.
module i2crf_bus_engine
    import i2crf_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [REG_W-1:0] rd_data,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [REG_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(REG_W + 1);

    bus_st_t          state;
    logic             scl_q, sda_q;
    logic [CNT_W-1:0] bitcnt;
    logic [REG_W-1:0] shreg, txreg;
    logic             ack_ph, rw, ai, mack_ok;
    logic             bus_start, bus_stop, scl_rise, scl_fall, byte_done;

    // Remember the previous filtered line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
    assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign byte_done = scl_fall && (bitcnt == CNT_W'(REG_W));

    // Protocol sequencer: receive, acknowledge, transmit and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ack_ph  <= 1'b0;
            rw      <= 1'b0;
            ai      <= 1'b0;
            ptr     <= '0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                state  <= ST_IDLE;
                ack_ph <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (!ack_ph) begin
                            if (scl_rise) begin
                                shreg  <= {shreg[REG_W-2:0], sda_f};
                                bitcnt <= bitcnt + CNT_W'(1);
                            end else if (byte_done) begin
                                if (state == ST_ADDR) begin
                                    if (shreg[REG_W-1:1] == SLAVE_ADDR) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        ack_ph <= 1'b1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_CMD) begin
                                    ptr    <= shreg[PTR_W-1:0];
                                    ai     <= shreg[4];
                                    sda_oe <= 1'b1;
                                    ack_ph <= 1'b1;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_ptr  <= ptr;
                                    wr_data <= shreg;
                                    if (ai) ptr <= ptr_next(ptr);
                                    sda_oe  <= 1'b1;
                                    ack_ph  <= 1'b1;
                                end
                            end
                        end else if (scl_fall) begin
                            ack_ph <= 1'b0;
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            if (state == ST_ADDR && rw) begin
                                state  <= ST_RDATA;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[REG_W-1];
                            end else if (state == ST_ADDR) begin
                                state <= ST_CMD;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                            if (ai) ptr <= ptr_next(ptr);
                        end else if (scl_fall && bitcnt != '0) begin
                            txreg  <= {txreg[REG_W-2:0], 1'b0};
                            sda_oe <= ~txreg[REG_W-2];
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_f;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                state  <= ST_RDATA;
                                bitcnt <= '0;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[REG_W-1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: an idle slave never holds SDA low
    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    // R8: outside START/STOP the slave moves SDA only while SCL is low
    p_oe_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(bus_start || bus_stop)) |-> !$past(scl_f));
    // R4: a write at the last location with auto-increment wraps to zero
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && !ack_ph && byte_done && ai && ptr == PTR_W'(NUM_REGS - 1))
        |=> (ptr == '0));
    // R9: a (repeated) START keeps the stored pointer
    p_start_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (ptr == $past(ptr)));
endmodule

// File: rtl/i2c_regfile_slave.sv
// Top of the I2C register-file slave: two spike filters, the protocol
// engine and the register bank, with register values broken out per field.
// Assumes scl_i/sda_i are already synchronised to clk.
module i2c_regfile_slave
    import i2crf_pkg::*;
#(
    parameter logic [6:0]       SLAVE_ADDR = 7'h62,
    parameter int               FILT_LEN   = 4,
    parameter logic [REG_W-1:0] PSC_RST    = 8'hFF,
    parameter logic [REG_W-1:0] DUTY_RST   = 8'h80,
    parameter logic [REG_W-1:0] LSEL_RST   = 8'h55
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [REG_W-1:0]    pins_i,
    output logic                sda_oe,
    output logic [REG_W-1:0]    presc0_o,
    output logic [REG_W-1:0]    duty0_o,
    output logic [REG_W-1:0]    presc1_o,
    output logic [REG_W-1:0]    duty1_o,
    output logic [REG_W-1:0]    ledsel_o,
    output logic [NUM_REGS-1:0] wr_stb_o
);
    logic [1:0]                raw_lines, filt_lines;
    logic [REG_W-1:0]          rd_data, wr_data;
    logic [PTR_W-1:0]          ptr, wr_ptr;
    logic                      wr_en;
    logic [NUM_REGS*REG_W-1:0] reg_flat;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_filt
        i2crf_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[l]), .filt_o(filt_lines[l])
        );
    end

    i2crf_bus_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_f(filt_lines[0]), .sda_f(filt_lines[1]),
        .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
    );

    i2crf_regbank #(.PSC_RST(PSC_RST), .DUTY_RST(DUTY_RST), .LSEL_RST(LSEL_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .rd_ptr(ptr), .pins_i(pins_i), .rd_data(rd_data), .reg_flat(reg_flat),
        .wr_stb(wr_stb_o)
    );

    assign presc0_o = reg_flat[IDX_PSC0*REG_W +: REG_W];
    assign duty0_o  = reg_flat[IDX_DUTY0*REG_W +: REG_W];
    assign presc1_o = reg_flat[IDX_PSC1*REG_W +: REG_W];
    assign duty1_o  = reg_flat[IDX_DUTY1*REG_W +: REG_W];
    assign ledsel_o = reg_flat[IDX_LSEL*REG_W +: REG_W];
endmodule

// File: tb/sim_i2c_regfile_slave.sv
// Bench: behavioural bus master plus a reference model of the register
// file, compared on every clock outside the byte in flight.
module sim_i2c_regfile_slave;
    localparam int CLK_P = 10;
    localparam int Q     = 12;
    localparam int FLT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] pins = 8'hA6;
    logic       sda_oe, sda_line;
    logic [7:0] presc0, duty0, presc1, duty1, ledsel;
    logic [5:0] wr_stb;

    int n_cmp = 0, n_bad = 0;
    bit busy = 1'b1, done = 1'b0;
    int m_reg[6];
    int m_ptr = 0;
    bit m_ai = 1'b0;
    int exp_stb[6], seen_stb[6];

    always #(CLK_P/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_regfile_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .pins_i(pins),
        .sda_oe(sda_oe), .presc0_o(presc0), .duty0_o(duty0), .presc1_o(presc1),
        .duty1_o(duty1), .ledsel_o(ledsel), .wr_stb_o(wr_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the register outputs against the model (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 6; i++) if (wr_stb[i]) seen_stb[i]++;
            if (!busy) begin
                check("R3 presc0", presc0, m_reg[1]);
                check("R3 duty0", duty0, m_reg[2]);
                check("R3 presc1", presc1, m_reg[3]);
                check("R3 duty1", duty1, m_reg[4]);
                check("R3 ledsel", ledsel, m_reg[5]);
            end
        end
    end

    function automatic int nxt(input int p);
        return (p >= 5) ? 0 : p + 1;
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    // One master bit; glitch 1 = short SCL low pulse, 2 = short SDA flip, both mid-high.
    task automatic send_bit(input bit b, input int glitch);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(Q/2);
        if (glitch == 1) begin m_scl = 1'b0; wq(FLT-1); m_scl = 1'b1; end
        if (glitch == 2) begin m_sda = ~b; wq(FLT-1); m_sda = b; end
        wq(Q/2); m_scl = 1'b0; wq(Q);
    endtask

    // Send a byte; is_data updates the model. Returns 1 when the slave acked.
    task automatic send_byte(input logic [7:0] b, input bit is_data, input int gl_bit,
                             input int gl_kind, output bit acked);
        if (is_data) busy = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gl_bit) ? gl_kind : 0);
        if (is_data) begin
            if (m_ptr >= 1 && m_ptr <= 5) begin m_reg[m_ptr] = b; exp_stb[m_ptr]++; end
            if (m_ai) m_ptr = (m_ptr >= 5) ? 0 : m_ptr + 1;
            busy = 1'b0;
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
        acked = (sda_line == 1'b0);
        wq(Q/2); m_scl = 1'b0; wq(Q);
    endtask

    // Receive one byte and compare against the model; mack 1 = master acks.
    task automatic recv_byte(input bit mack, input string req);
        logic [7:0] d = '0;
        int e = (m_ptr == 0) ? int'(pins) : (m_ptr <= 5 ? m_reg[m_ptr] : 0);
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
            d = {d[6:0], sda_line};
            wq(Q/2); m_scl = 1'b0; wq(Q);
        end
        check(req, d, e);
        if (m_ai) m_ptr = nxt(m_ptr);
        m_sda = mack ? 1'b0 : 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
        if (!mack) check("R8 released on nack", sda_line, 1);
        wq(Q/2); m_scl = 1'b0; wq(Q);
    endtask

    task automatic addr(input logic [7:0] b, input int exp_ack, input string req);
        bit a;
        send_byte(b, 1'b0, -1, 0, a);
        check(req, a, exp_ack);
    endtask

    task automatic cmd(input logic [7:0] b);
        bit a;
        send_byte(b, 1'b0, -1, 0, a);
        check("R2 command ack", a, 1);
        m_ptr = b[2:0]; m_ai = b[4];
    endtask

    task automatic wdata(input logic [7:0] b, input string req);
        bit a;
        send_byte(b, 1'b1, -1, 0, a);
        check(req, a, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        m_reg[0] = 0; m_reg[1] = 'hFF; m_reg[2] = 'h80; m_reg[3] = 'hFF;
        m_reg[4] = 'h80; m_reg[5] = 'h55;
        for (int i = 0; i < 6; i++) begin exp_stb[i] = 0; seen_stb[i] = 0; end
        wq(5); rst_n = 1'b1; wq(2);
        // R12: reset state
        check("R12 sda released", sda_oe, 0);
        check("R12 presc0", presc0, 'hFF); check("R12 duty0", duty0, 'h80);
        check("R12 presc1", presc1, 'hFF); check("R12 duty1", duty1, 'h80);
        check("R12 ledsel", ledsel, 'h55);
        busy = 1'b0;

        // R1 R3 R4: burst write of all five locations with wrap
        bus_start(); addr(8'hC4, 1, "R1 write address ack");
        cmd(8'h11);
        wdata(8'h25, "R3 ack"); wdata(8'h80, "R3 ack"); wdata(8'h09, "R3 ack");
        wdata(8'hC0, "R3 ack"); wdata(8'hE4, "R4 ack last");
        bus_stop();
        check("R4 model pointer wrapped", m_ptr, 0);

        // R11 R4 R8: read without command byte continues from wrapped pointer
        bus_start(); addr(8'hC5, 1, "R1 read address ack");
        recv_byte(1'b1, "R11 read pins first");
        recv_byte(1'b1, "R4 read presc0");
        recv_byte(1'b0, "R8 read duty0 then nack");
        bus_stop();

        // R5: no auto-increment keeps hitting location 3
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h03);
        wdata(8'h5A, "R5 ack"); wdata(8'h3C, "R5 ack");
        bus_stop();

        // R9 R5: command then repeated START, two reads of same location
        pins = 8'h3B;
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h02);
        bus_start(); addr(8'hC5, 1, "R9 read after repeated start");
        recv_byte(1'b1, "R5 repeated duty0 a"); recv_byte(1'b0, "R5 repeated duty0 b");
        bus_stop();

        // R6: write to pin location is acked and ignored
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h00);
        wdata(8'h77, "R6 ack on read-only");
        bus_stop();
        for (int i = 0; i < 6; i++) check("R7 R6 strobe count", seen_stb[i], exp_stb[i]);

        // R1: foreign address not acked and rest ignored
        bus_start(); addr(8'hC6, 0, "R1 foreign address nack");
        send_byte(8'h12, 1'b0, -1, 0, a);
        check("R1 foreign data nack", a, 0);
        bus_stop();

        // R4: pointer 6 ignores writes and wraps to 0; then read pins
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h16);
        wdata(8'h99, "R4 ack at code 6");
        bus_stop();
        bus_start(); addr(8'hC5, 1, "R1 ack");
        recv_byte(1'b0, "R4 read after wrap from 6");
        bus_stop();

        // R4 R8: read burst wraps from selector to pins
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h15);
        bus_start(); addr(8'hC5, 1, "R9 ack");
        recv_byte(1'b1, "R4 read ledsel"); recv_byte(1'b0, "R4 read wraps to pins");
        bus_stop();

        // R10: spikes on SCL and SDA inside data bits are ignored
        bus_start(); addr(8'hC4, 1, "R1 ack"); cmd(8'h14);
        send_byte(8'hA5, 1'b1, 5, 1, a); check("R10 scl spike ack", a, 1);
        send_byte(8'h3C, 1'b1, 2, 2, a); check("R10 sda spike ack", a, 1);
        bus_stop();
        check("R10 duty1 intact", duty1, 'hA5);
        check("R10 ledsel intact", ledsel, 'h3C);
        for (int i = 0; i < 6; i++) check("R7 strobe count", seen_stb[i], exp_stb[i]);
        check("R7 no strobe on pins", seen_stb[0], 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule